// File: doc/BRIEF.md
# Sliced Wide-Word Dual-Port Memory

This block holds an array of user words that are wider than the 16-bit register bus. Each word is cut into 16-bit slices, and each slice lives in its own bank. Slice 0 takes the least significant bits. When the width is not a multiple of 16, the top bank is narrower. One side of the block is a user port that reads or writes a whole word in one cycle. The other side is a simple register-bus port that reaches each bank through its own contiguous address window. The windows are stacked one above the other, starting at a base address.

A mode parameter decides who may write. In bidirectional mode both sides write. In capture mode the user side writes and the bus only reads, which suits buffers that logic fills and a host reads out. In playback mode the bus writes and the user side only reads, which suits tables that a host loads and logic consumes.

Top module: `wmem_top`

## Requirements
- R1: With NB = ceil(WIDTH/16) banks, bits [16i+15:16i] of user word a are reachable on the bus at address BASE + a + i*DEPTH. Slice 0 holds bits [15:0].
- R2: The last bank stores only WIDTH mod 16 bits when that value is non-zero. A bus read of that bank returns those bits zero-extended to 16. A bus write to that bank drops the data bits above them.
- R3: After reset every location reads as zero, both from the bus and from the user port.
- R4: A user write (userWrEn high for one clock) updates all WIDTH bits of the word at userAddr in that clock. userRdData shows the word at the userAddr of the previous clock.
- R5: busRdValid is high in exactly the clock after a busRdEn with an in-window address, and busRdData carries the addressed slice in that clock. In every other clock busRdValid is low and busRdData is zero.
- R6: Bus accesses outside BASE .. BASE + NB*DEPTH - 1 are ignored. A write there changes no location, and a read there gives no busRdValid.
- R7: A bus-written value reads back unchanged from the bus, masked per R2, whatever other bus writes and reads are interleaved.
- R8: MODE 0 (bidirectional) lets both sides write. MODE 1 (capture) ignores bus writes. MODE 2 (playback) ignores user writes. Reads work on both sides in every mode.
- R9: In bidirectional mode, a user write and a bus write that hit the same location in the same clock leave the user data there. Writes that hit different locations in the same clock both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| userAddr | input | $clog2(DEPTH) | User word address |
| userWrData | input | WIDTH | User write word |
| userWrEn | input | 1 | User write enable |
| userRdData | output | WIDTH | User read word, one clock after the address |
| busAddr | input | 16 | Bus address |
| busWrData | input | 16 | Bus write data |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busRdData | output | 16 | Bus read data, zero when not valid |
| busRdValid | output | 1 | Bus read data valid |

## Verification
The assertions check several rules on every clock. They check the one-clock link from an in-window read strobe to busRdValid, and that out-of-window reads give no valid. They check that busRdData is zero whenever it is not valid, and that the upper bits of the narrow bank always read as zero. In playback mode they check that user read data holds steady while no bus write occurs.

Other behaviour can only be shown by the bench's scenarios, because it depends on what was stored earlier. This covers the slice-to-address layout, the reset clearing, read-back after scrambled and interleaved bus traffic, and writes that a mode ignores. It also covers which side wins when a user write and a bus write hit the same location in the same clock.

// File: rtl/wmem_pkg.sv
package wmem_pkg;

  typedef enum logic [1:0] {
    MODE_BIDIR   = 2'd0,
    MODE_USER_WR = 2'd1,
    MODE_BUS_WR  = 2'd2
  } accessMode_e;

  // Strobes from control to datapath; widths are upper bounds, the
  // datapath takes the low bits it needs.
  typedef struct packed {
    logic        userWr;
    logic        busWr;
    logic        busRd;
    logic [7:0]  busBank;
    logic [15:0] busOff;
  } memStrobes_t;

endpackage

// File: rtl/wmem_ctrl.sv
module wmem_ctrl
  import wmem_pkg::*;
#(
  parameter int          WIDTH = 23,
  parameter int          DEPTH = 64,
  parameter logic [15:0] BASE  = 16'h0100,
  parameter accessMode_e MODE  = MODE_BIDIR,
  parameter int          AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0] userAddr,
  input  logic          userWrEn,
  input  logic [15:0]   busAddr,
  input  logic          busWrEn,
  input  logic          busRdEn,
  output memStrobes_t   strobes
);
  localparam int          NB     = (WIDTH + 15) / 16;
  localparam logic [16:0] winLo  = 17'(BASE);
  localparam logic [16:0] winHi  = 17'(int'(BASE) + NB * DEPTH);
  localparam logic [16:0] depthW = 17'(DEPTH);
  localparam logic [AW:0] depthU = (AW+1)'(DEPTH);

  logic [16:0] busAddrX;
  logic [16:0] rel;
  logic        inWin;
  logic        userInRange;

  always_comb begin
    busAddrX    = {1'b0, busAddr};
    rel         = busAddrX - winLo;
    inWin       = (busAddrX >= winLo) && (busAddrX < winHi);
    userInRange = {1'b0, userAddr} < depthU;

    strobes.busRd   = busRdEn && inWin;
    strobes.busWr   = busWrEn && inWin && (MODE != MODE_USER_WR);
    strobes.userWr  = userWrEn && userInRange && (MODE != MODE_BUS_WR);
    strobes.busBank = 8'(rel / depthW);
    strobes.busOff  = 16'(rel % depthW);
  end

endmodule

// File: rtl/wmem_datapath.sv
module wmem_datapath
  import wmem_pkg::*;
#(
  parameter int WIDTH = 23,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  memStrobes_t      strobes,
  input  logic [AW-1:0]    userAddr,
  input  logic [WIDTH-1:0] userWrData,
  input  logic [15:0]      busWrData,
  output logic [WIDTH-1:0] userRdData,
  output logic [15:0]      busRdData,
  output logic             busRdValid
);
  localparam int NB    = (WIDTH + 15) / 16;
  localparam int LASTW = WIDTH - 16 * (NB - 1);
  localparam int BKW   = (NB > 1) ? $clog2(NB) : 1;

  logic [AW-1:0]    offIdx;
  logic [BKW-1:0]   bankIdx;
  logic [15:0]      bankBusWord [NB];
  logic [WIDTH-1:0] userWordNow;
  logic             unusedOffHi;

  assign offIdx      = strobes.busOff[AW-1:0];
  assign bankIdx     = strobes.busBank[BKW-1:0];
  assign unusedOffHi = ^strobes.busOff[15:AW];

  for (genvar b = 0; b < NB; b++) begin : gBank
    localparam int BW = (b == NB - 1) ? LASTW : 16;
    logic [BW-1:0] cells [DEPTH];

    // Bus write first, user write last: same-location collision keeps user data.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else begin
        if (strobes.busWr && (strobes.busBank == 8'(b)))
          cells[offIdx] <= busWrData[BW-1:0];
        if (strobes.userWr)
          cells[userAddr] <= userWrData[b*16 +: BW];
      end
    end

    assign userWordNow[b*16 +: BW] = cells[userAddr];

    if (BW == 16) begin : gFull
      assign bankBusWord[b] = cells[offIdx];
    end else begin : gNarrow
      assign bankBusWord[b] = {{(16 - BW){1'b0}}, cells[offIdx]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      userRdData <= '0;
      busRdData  <= '0;
      busRdValid <= 1'b0;
    end else begin
      userRdData <= userWordNow;
      busRdValid <= strobes.busRd;
      busRdData  <= strobes.busRd ? bankBusWord[bankIdx] : 16'h0000;
    end
  end

  // R5
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdValid |-> (busRdData == 16'h0000));

  if (LASTW < 16) begin : gNarrowChk
    // R2
    narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(strobes.busRd) && ($past(strobes.busBank) == 8'(NB - 1)))
        |-> (busRdData[15:LASTW] == '0));
  end

endmodule

// File: rtl/wmem_top.sv
module wmem_top
  import wmem_pkg::*;
#(
  parameter int          WIDTH = 23,
  parameter int          DEPTH = 64,
  parameter logic [15:0] BASE  = 16'h0100,
  parameter accessMode_e MODE  = MODE_BIDIR,
  localparam int         AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    userAddr,
  input  logic [WIDTH-1:0] userWrData,
  input  logic             userWrEn,
  output logic [WIDTH-1:0] userRdData,
  input  logic [15:0]      busAddr,
  input  logic [15:0]      busWrData,
  input  logic             busWrEn,
  input  logic             busRdEn,
  output logic [15:0]      busRdData,
  output logic             busRdValid
);
  localparam int NB      = (WIDTH + 15) / 16;
  localparam int WIN_END = int'(BASE) + NB * DEPTH;

  memStrobes_t strobes;

  wmem_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .BASE(BASE), .MODE(MODE), .AW(AW)) ctrl_i (
    .userAddr(userAddr), .userWrEn(userWrEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .strobes(strobes)
  );

  wmem_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .userAddr(userAddr),
    .userWrData(userWrData), .busWrData(busWrData), .userRdData(userRdData),
    .busRdData(busRdData), .busRdValid(busRdValid)
  );

  logic inRange;
  assign inRange = ({1'b0, busAddr} >= 17'(BASE)) && ({1'b0, busAddr} < 17'(WIN_END));

  // R5
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && inRange) |=> busRdValid);

  // R6
  out_of_window_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdEn && inRange) |=> !busRdValid);

  if (MODE == MODE_BUS_WR) begin : gPlaybackChk
    // R8
    user_side_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($stable(userAddr) && !$past(busWrEn)) |=> $stable(userRdData));
  end

endmodule

// File: tb/wmem_top_tb_top.sv
module wmem_top_tb_top;
  import wmem_pkg::*;

  localparam int          WIDTH = 23;
  localparam int          DEPTH = 64;
  localparam logic [15:0] BASE  = 16'h0100;
  localparam int          AW    = $clog2(DEPTH);
  localparam int          NWORD = 2 * DEPTH;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [AW-1:0]    userAddr = '0;
  logic [WIDTH-1:0] userWrData = '0;
  logic             userWrEn = 1'b0;
  logic [15:0]      busAddr = '0;
  logic [15:0]      busWrData = '0;
  logic             busWrEn = 1'b0;
  logic             busRdEn = 1'b0;
  logic [WIDTH-1:0] uRd [3];
  logic [15:0]      bRd [3];
  logic             bVal [3];

  int total = 0;
  int bad = 0;
  logic [15:0] bm [NWORD];

  always #4 clk = ~clk;

  wmem_top #(.WIDTH(WIDTH), .DEPTH(DEPTH), .BASE(BASE), .MODE(MODE_BIDIR)) dut_i (
    .clk(clk), .rstN(rstN), .userAddr(userAddr), .userWrData(userWrData), .userWrEn(userWrEn),
    .userRdData(uRd[0]), .busAddr(busAddr), .busWrData(busWrData), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busRdData(bRd[0]), .busRdValid(bVal[0]));
  wmem_top #(.WIDTH(WIDTH), .DEPTH(DEPTH), .BASE(BASE), .MODE(MODE_USER_WR)) dutCap_i (
    .clk(clk), .rstN(rstN), .userAddr(userAddr), .userWrData(userWrData), .userWrEn(userWrEn),
    .userRdData(uRd[1]), .busAddr(busAddr), .busWrData(busWrData), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busRdData(bRd[1]), .busRdValid(bVal[1]));
  wmem_top #(.WIDTH(WIDTH), .DEPTH(DEPTH), .BASE(BASE), .MODE(MODE_BUS_WR)) dutPlay_i (
    .clk(clk), .rstN(rstN), .userAddr(userAddr), .userWrData(userWrData), .userWrEn(userWrEn),
    .userRdData(uRd[2]), .busAddr(busAddr), .busWrData(busWrData), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busRdData(bRd[2]), .busRdValid(bVal[2]));

  function automatic logic [15:0] maskOf(int a);
    return (a - int'(BASE) >= DEPTH) ? 16'h007F : 16'hFFFF;
  endfunction

  function automatic logic [15:0] pat(int a);
    return 16'(a * 40503) ^ 16'h1234;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(int a, logic [15:0] d);
    busAddr = 16'(a); busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(int a);
    busAddr = 16'(a); busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic userWrite(int a, logic [WIDTH-1:0] d);
    userAddr = AW'(a); userWrData = d; userWrEn = 1'b1;
    @(negedge clk);
    userWrEn = 1'b0;
  endtask

  task automatic userRead(int a);
    userAddr = AW'(a);
    @(negedge clk);
  endtask

  task automatic tReset();
    for (int a = 0; a < NWORD; a++) begin
      busRead(int'(BASE) + a);
      check("R3 bus valid", 32'(bVal[0]), 32'd1);
      check("R3 bus zero", 32'(bRd[0]), 32'd0);
    end
    for (int a = 0; a < DEPTH; a += 9) begin
      userRead(a);
      check("R3 user zero", 32'(uRd[0]), 32'd0);
    end
  endtask

  task automatic tUserToBus();
    userWrite(5, 23'h5ABCDE);
    userRead(5);
    check("R4 user readback", 32'(uRd[0]), 32'h5ABCDE);
    busRead(int'(BASE) + 5);
    check("R1 slice0", 32'(bRd[0]), 32'hBCDE);
    check("R8 capture slice0", 32'(bRd[1]), 32'hBCDE);
    check("R8 playback ignores user", 32'(bRd[2]), 32'h0);
    busRead(int'(BASE) + 5 + DEPTH);
    check("R1 slice1", 32'(bRd[0]), 32'h005A);
    check("R2 slice1 capture", 32'(bRd[1]), 32'h005A);
  endtask

  task automatic tNarrow();
    busWrite(int'(BASE) + 16 + DEPTH, 16'hFFFF);
    busRead(int'(BASE) + 16 + DEPTH);
    check("R2 narrow bus read", 32'(bRd[0]), 32'h007F);
    check("R8 capture ignores bus", 32'(bRd[1]), 32'h0);
    userRead(16);
    check("R2 narrow user view", 32'(uRd[0]), 32'h7F0000);
    check("R2 playback user view", 32'(uRd[2]), 32'h7F0000);
  endtask

  task automatic tBusTraffic();
    for (int k = 0; k < NWORD; k++) begin
      int a = int'(BASE) + ((k * 37) % NWORD);
      busWrite(a, pat(a));
      bm[a - int'(BASE)] = pat(a) & maskOf(a);
    end
    for (int k = 0; k < NWORD; k++) begin
      int a = int'(BASE) + ((k * 91 + 5) % NWORD);
      busRead(a);
      check("R7 scrambled readback", 32'(bRd[0]), 32'(bm[a - int'(BASE)]));
    end
    for (int k = 0; k < 24; k++) begin
      int w = int'(BASE) + ((k * 53) % NWORD);
      int r = int'(BASE) + ((k * 29 + 11) % NWORD);
      busWrite(w, ~pat(w));
      bm[w - int'(BASE)] = ~pat(w) & maskOf(w);
      busRead(r);
      check("R7 interleaved", 32'(bRd[0]), 32'(bm[r - int'(BASE)]));
    end
  endtask

  task automatic tValidAndWindow();
    busRead(int'(BASE) - 1);
    check("R6 below window valid", 32'(bVal[0]), 32'd0);
    check("R5 below window data", 32'(bRd[0]), 32'd0);
    busRead(int'(BASE) + NWORD);
    check("R6 above window valid", 32'(bVal[0]), 32'd0);
    busRead(int'(BASE) + NWORD - 1);
    check("R5 valid last addr", 32'(bVal[0]), 32'd1);
    @(negedge clk);
    check("R5 valid drops", 32'(bVal[0]), 32'd0);
    check("R5 data zero idle", 32'(bRd[0]), 32'd0);
    busWrite(int'(BASE) - 1, 16'hFFFF);
    busWrite(int'(BASE) + NWORD, 16'hFFFF);
    busRead(int'(BASE));
    check("R6 low edge intact", 32'(bRd[0]), 32'(bm[0]));
    busRead(int'(BASE) + NWORD - 1);
    check("R6 high edge intact", 32'(bRd[0]), 32'(bm[NWORD - 1]));
  endtask

  task automatic tModes();
    logic [WIDTH-1:0] x = 23'h3C_A55A;
    userWrite(20, x);
    busWrite(int'(BASE) + 20, 16'h0F0F);
    bm[20] = 16'h0F0F;
    busRead(int'(BASE) + 20);
    check("R8 bidir bus write", 32'(bRd[0]), 32'h0F0F);
    check("R8 capture keeps user data", 32'(bRd[1]), 32'(x[15:0]));
    userRead(20);
    check("R8 bidir mixed word", 32'(uRd[0]), {9'h0, x[22:16], 16'h0F0F});
    check("R8 playback word", 32'(uRd[2]),
          {9'h0, bm[20 + DEPTH][6:0], 16'h0F0F});
  endtask

  task automatic tCollide();
    userAddr = AW'(7); userWrData = 23'h11_2233; userWrEn = 1'b1;
    busAddr = BASE + 16'd7; busWrData = 16'hEEEE; busWrEn = 1'b1;
    @(negedge clk);
    userAddr = AW'(8); userWrData = 23'h00_4444;
    busAddr = BASE + 16'd9; busWrData = 16'h9999;
    @(negedge clk);
    userWrEn = 1'b0; busWrEn = 1'b0;
    busRead(int'(BASE) + 7);
    check("R9 user wins collision", 32'(bRd[0]), 32'h2233);
    busRead(int'(BASE) + 8);
    check("R9 separate user write", 32'(bRd[0]), 32'h4444);
    busRead(int'(BASE) + 9);
    check("R9 separate bus write", 32'(bRd[0]), 32'h9999);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R5 reset valid low", 32'(bVal[0]), 32'd0);
    tReset();
    tUserToBus();
    tNarrow();
    tBusTraffic();
    tValidAndWindow();
    tModes();
    tCollide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule